// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

A single-clock static RAM that accepts a read, a write or a deselect on every rising clock edge. Any order of these commands runs back to back with no idle cycle in between. A write sends its address first and its data later: one edge later in flow-through mode and two edges later in pipelined mode. A read must always see the newest data. Any read that follows a write to the same word therefore returns the new bytes, even when those bytes have not yet reached the storage array. Pipelined mode adds an output register, so read data appears one cycle later than in flow-through mode.

Each word is made of 9-bit bytes, and each byte has its own write enable. Three chip enables make depth expansion possible. A two-bit burst sequencer lets one address start a four-beat access in linear or interleaved order. An asynchronous output enable and a sleep input can turn the data outputs off at any time. Sleep also stops new commands from being accepted. The data bus is modelled as `q` plus a drive flag `q_oe`. When the flag is low, `q` reads as zero.

Top module: `zt_sram`

## Requirements
- R1: While `rst` is high, and after it is released, `q_oe` stays 0 and `q` stays 0 until a read has been accepted.
- R2: A new access starts on a rising edge only when `adv`=0, `en_a_n`=0, `en_b`=1 and `en_c_n`=0. `we_n`=0 selects a write and `we_n`=1 selects a read. Any other enable combination with `adv`=0 is a deselect, and no command is issued.
- R3: In pipelined mode (`pipe_mode`=1), a read accepted at edge k drives its data on `q` after edge k+1, until edge k+2. In flow-through mode (`pipe_mode`=0), the data is driven after edge k, until edge k+1.
- R4: The data of a write accepted at edge k is taken from `din` at edge k+2 in pipelined mode, and at edge k+1 in flow-through mode.
- R5: Reads, writes and deselects may follow each other on every edge in any mix. A read always returns the data of every write accepted before it, including writes whose data is taken on the same edge that loads the output register.
- R6: For a write, `bw_n[i]`=0 writes bits [9i+8:9i] of the word, and `bw_n[i]`=1 leaves those bits unchanged. `bw_n` is sampled with the address of each beat.
- R7: `adv`=1 continues the last started access, with the same operation and the same address bits above bit 1. For beat n (n=1,2,3, wrapping), the low two bits are (start+n) mod 4 when `ilv_order`=0, and start XOR n when `ilv_order`=1. The chip enables and `we_n` are ignored on such beats. `adv`=1 after a deselect is a deselect.
- R8: `oe_n`=1 turns the output off at once (`q_oe`=0) without disturbing any access in flight. Releasing it during a valid read cycle brings the read data back.
- R9: While `sleep`=1, no command is accepted, the burst state is frozen and the output is off. Data still owed to writes accepted earlier is taken as usual, and the stored contents are kept.
- R10: Whenever `q_oe`=0, `q` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through (static outside reset) |
| ilv_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 = continue the burst, 0 = new access or deselect |
| we_n | input | 1 | 0 = write, 1 = read |
| bw_n | input | 2 | Per-byte write enables, active low |
| addr | input | 8 | Word address |
| din | input | 18 | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous power-down request |
| q | output | 18 | Read data, zero when not driven |
| q_oe | output | 1 | High while `q` is driven |

## Verification
The bench aims at read-after-write hazards on a small address window. There, a missing or misaligned bypass returns the old array word instead of the freshly written bytes, and a write committed from the wrong stage lands one cycle early or late with the wrong data. Partial byte writes expose a merge that copies whole words. Bursts in both orders, started from non-zero low bits, expose a counter that wraps or combines the low bits wrongly. A burst continued after a deselect catches a sequencer that keeps stale state. Toggles of sleep and output enable in the middle of a read catch outputs that are not cut off at once, and sleep-time writes that wrongly modify memory.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    localparam int AW      = 8;
    localparam int NB      = 2;
    localparam int BYTE_W  = 9;
    localparam int DW      = NB * BYTE_W;
    localparam int DEPTH   = 1 << AW;
    localparam int SEQ_W   = 2;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [AW-1:0]   addr;
        logic [NB-1:0]   bwe;
    } cmd_t;

    // low address bits of a burst beat
    function automatic logic [SEQ_W-1:0] seq_low(input logic [SEQ_W-1:0] start,
                                                 input logic [SEQ_W-1:0] beat,
                                                 input logic             ilv);
        if (ilv)
            seq_low = start ^ beat;
        else
            seq_low = SEQ_W'(start + beat);
    endfunction

    // overlay enabled bytes of upd onto base
    function automatic logic [DW-1:0] byte_merge(input logic [DW-1:0] base,
                                                 input logic [DW-1:0] upd,
                                                 input logic [NB-1:0] en);
        byte_merge = base;
        for (int b = 0; b < NB; b++) begin
            if (en[b])
                byte_merge[b*BYTE_W +: BYTE_W] = upd[b*BYTE_W +: BYTE_W];
        end
    endfunction

endpackage

// File: rtl/zt_cmd_decode.sv
module zt_cmd_decode
    import zt_sram_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           sleep,
    input  logic           ilv_order,
    input  logic           en_a_n,
    input  logic           en_b,
    input  logic           en_c_n,
    input  logic           adv,
    input  logic           we_n,
    input  logic [NB-1:0]  bw_n,
    input  logic [AW-1:0]  addr,
    output cmd_t           iss
);

    op_e              b_op;
    logic [AW-1:0]    b_base;
    logic [SEQ_W-1:0] b_cnt;
    logic [SEQ_W-1:0] nxt_cnt;
    logic             chip_sel;

    assign chip_sel = !en_a_n && en_b && !en_c_n;
    assign nxt_cnt  = SEQ_W'(b_cnt + 1'b1);

    always_comb begin
        iss      = '0;
        iss.op   = OP_NONE;
        iss.addr = addr;
        iss.bwe  = ~bw_n;
        if (!rst && !sleep) begin
            if (adv) begin
                iss.op   = b_op;
                iss.addr = {b_base[AW-1:SEQ_W], seq_low(b_base[SEQ_W-1:0], nxt_cnt, ilv_order)};
            end else if (chip_sel) begin
                iss.op = we_n ? OP_RD : OP_WR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_op   <= OP_NONE;
            b_base <= '0;
            b_cnt  <= '0;
        end else if (!sleep) begin
            if (adv) begin
                if (b_op != OP_NONE)
                    b_cnt <= nxt_cnt;
            end else begin
                b_op   <= iss.op;
                b_base <= addr;
                b_cnt  <= '0;
            end
        end
    end

    // R7: a continued beat stays inside the aligned group of four
    a_r7_burst_group: assert property (@(posedge clk) disable iff (rst)
        (adv && !sleep && iss.op != OP_NONE && !$past(rst) && $past(iss.op) != OP_NONE && !$past(sleep))
        |-> iss.addr[AW-1:SEQ_W] == $past(iss.addr[AW-1:SEQ_W]));

endmodule

// File: rtl/zt_wr_pipe.sv
module zt_wr_pipe
    import zt_sram_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           pipe_mode,
    input  cmd_t           iss,
    output cmd_t           st1,
    output cmd_t           st2,
    output logic           wr_en,
    output logic [AW-1:0]  wr_addr,
    output logic [NB-1:0]  wr_bwe
);

    cmd_t commit_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            st1 <= '0;
            st2 <= '0;
        end else begin
            st1 <= iss;
            st2 <= st1;
        end
    end

    // double late write takes the older stage, single late write the newer
    assign commit_src = pipe_mode ? st2 : st1;
    assign wr_en      = (commit_src.op == OP_WR);
    assign wr_addr    = commit_src.addr;
    assign wr_bwe     = commit_src.bwe;

    // R4: pipelined commit belongs to a write issued two edges earlier
    a_r4_double_late: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && wr_en && !$past(rst) && !$past(rst, 2))
        |-> $past(iss.op, 2) == OP_WR);

    // R4: flow-through commit belongs to a write issued one edge earlier
    a_r4_single_late: assert property (@(posedge clk) disable iff (rst)
        (!pipe_mode && wr_en && !$past(rst))
        |-> $past(iss.op) == OP_WR);

endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array
    import zt_sram_pkg::*;
(
    input  logic           clk,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [NB-1:0]  wr_bwe,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data
);

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [BYTE_W-1:0] lane [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_bwe[b])
                lane[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
        end

        assign rd_data[b*BYTE_W +: BYTE_W] = lane[rd_addr];
    end

endmodule

// File: rtl/zt_rd_path.sv
module zt_rd_path
    import zt_sram_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           pipe_mode,
    input  logic           oe_n,
    input  logic           sleep,
    input  cmd_t           st1,
    input  cmd_t           st2,
    input  logic [DW-1:0]  din,
    input  logic [DW-1:0]  mem_rd,
    output logic [DW-1:0]  q,
    output logic           q_oe
);

    logic [DW-1:0] fwd_word;
    logic          fwd_hit;
    logic          oreg_v;
    logic [DW-1:0] oreg_d;
    logic          data_v;
    logic [DW-1:0] data_w;

    // in pipelined mode the older write's data is on din while its read loads
    assign fwd_hit  = pipe_mode && (st2.op == OP_WR) && (st2.addr == st1.addr);
    assign fwd_word = fwd_hit ? byte_merge(mem_rd, din, st2.bwe) : mem_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            oreg_v <= 1'b0;
            oreg_d <= '0;
        end else begin
            oreg_v <= (st1.op == OP_RD);
            oreg_d <= fwd_word;
        end
    end

    assign data_v = pipe_mode ? oreg_v : (st1.op == OP_RD);
    assign data_w = pipe_mode ? oreg_d : mem_rd;
    assign q_oe   = data_v && !oe_n && !sleep;
    assign q      = q_oe ? data_w : '0;

    // R3: pipelined read shows up one edge after its stage-1 cycle
    a_r3_pipe_latency: assert property (@(posedge clk) disable iff (rst)
        (pipe_mode && !$past(rst) && $past(st1.op) == OP_RD && !oe_n && !sleep)
        |-> q_oe);

    // R8 / R10: disabled output drives nothing
    a_r8_oe_override: assert property (@(posedge clk) disable iff (rst)
        (oe_n || sleep) |-> (!q_oe && q == '0));

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           pipe_mode,
    input  logic           ilv_order,
    input  logic           en_a_n,
    input  logic           en_b,
    input  logic           en_c_n,
    input  logic           adv,
    input  logic           we_n,
    input  logic [NB-1:0]  bw_n,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  din,
    input  logic           oe_n,
    input  logic           sleep,
    output logic [DW-1:0]  q,
    output logic           q_oe
);

    cmd_t           iss;
    cmd_t           st1;
    cmd_t           st2;
    logic           wr_en;
    logic [AW-1:0]  wr_addr;
    logic [NB-1:0]  wr_bwe;
    logic [DW-1:0]  mem_rd;

    zt_cmd_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .sleep     (sleep),
        .ilv_order (ilv_order),
        .en_a_n    (en_a_n),
        .en_b      (en_b),
        .en_c_n    (en_c_n),
        .adv       (adv),
        .we_n      (we_n),
        .bw_n      (bw_n),
        .addr      (addr),
        .iss       (iss)
    );

    zt_wr_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .pipe_mode (pipe_mode),
        .iss       (iss),
        .st1       (st1),
        .st2       (st2),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_bwe    (wr_bwe)
    );

    zt_mem_array u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bwe  (wr_bwe),
        .wr_data (din),
        .rd_addr (st1.addr),
        .rd_data (mem_rd)
    );

    zt_rd_path u_rd (
        .clk       (clk),
        .rst       (rst),
        .pipe_mode (pipe_mode),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .st1       (st1),
        .st2       (st2),
        .din       (din),
        .mem_rd    (mem_rd),
        .q         (q),
        .q_oe      (q_oe)
    );

    // R2: a new-access cycle without full selection leaves stage 1 idle
    a_r2_deselect_idle: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !adv && (en_a_n || !en_b || en_c_n)) |=> st1.op == OP_NONE);

    // R9: nothing enters the pipe while asleep
    a_r9_sleep_blocks: assert property (@(posedge clk) disable iff (rst)
        sleep |=> st1.op == OP_NONE);

    // R1: reset leaves the outputs quiet on the following cycle
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !q_oe);

endmodule

// File: tb/tb_zt_sram.sv
`timescale 1ns/1ps
module tb_zt_sram;
    import zt_sram_pkg::*;

    logic          clk = 1'b0;
    logic          rst;
    logic          pipe_mode, ilv_order;
    logic          en_a_n, en_b, en_c_n, adv, we_n;
    logic [NB-1:0] bw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic          oe_n, sleep;
    logic [DW-1:0] q;
    logic          q_oe;

    always #5 clk = ~clk;

    zt_sram dut (
        .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .ilv_order(ilv_order),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .adv(adv), .we_n(we_n),
        .bw_n(bw_n), .addr(addr), .din(din), .oe_n(oe_n), .sleep(sleep),
        .q(q), .q_oe(q_oe)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    int    cyc_n = 0;
    logic [DW-1:0] sched [int];

    // ---------------- reference model ----------------
    logic [DW-1:0] rmem [DEPTH];
    bit            started = 0;
    int            p1_op, p1_addr, p2_op, p2_addr;
    logic [NB-1:0] p1_bwe, p2_bwe;
    int            mb_op, mb_base, mb_cnt;
    bit            exp_v = 0;
    logic [DW-1:0] exp_d = '0;

    task automatic model_commit(input int a, input logic [NB-1:0] be);
        for (int b = 0; b < NB; b++)
            if (be[b]) rmem[a][b*BYTE_W +: BYTE_W] = din[b*BYTE_W +: BYTE_W];
    endtask

    always @(posedge clk) begin
        int c_op, c_addr, lo;
        logic [NB-1:0] c_bwe;
        started = 1;
        if (rst) begin
            p1_op = 0; p2_op = 0; mb_op = 0; mb_cnt = 0; exp_v = 0;
        end else begin
            c_op = 0; c_addr = int'(addr); c_bwe = ~bw_n;
            if (!sleep) begin
                if (adv) begin
                    if (mb_op != 0) begin
                        mb_cnt = (mb_cnt + 1) % 4;
                        lo = ilv_order ? ((mb_base % 4) ^ mb_cnt) : (((mb_base % 4) + mb_cnt) % 4);
                        c_op = mb_op;
                        c_addr = (mb_base / 4) * 4 + lo;
                    end
                end else if (en_a_n == 1'b0 && en_b == 1'b1 && en_c_n == 1'b0) begin
                    c_op = we_n ? 1 : 2;
                    mb_op = c_op; mb_base = int'(addr); mb_cnt = 0;
                end else begin
                    mb_op = 0;
                end
            end
            if (pipe_mode) begin
                if (p2_op == 2) model_commit(p2_addr, p2_bwe);
                exp_v = (p1_op == 1);
                if (exp_v) exp_d = rmem[p1_addr];
            end else begin
                if (p1_op == 2) model_commit(p1_addr, p1_bwe);
                exp_v = (c_op == 1);
                if (exp_v) exp_d = rmem[c_addr];
            end
            p2_op = p1_op; p2_addr = p1_addr; p2_bwe = p1_bwe;
            p1_op = c_op;  p1_addr = c_addr;  p1_bwe = c_bwe;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        bit            e_oe;
        logic [DW-1:0] e_q;
        if (started) begin
            e_oe = exp_v && !oe_n && !sleep;
            e_q  = e_oe ? exp_d : '0;
            n_chk++;
            if (q_oe !== e_oe || q !== e_q) begin
                n_bad++;
                $display("FAIL %s cycle %0d: q_oe=%0b q=%h expected q_oe=%0b q=%h",
                         cur_req, cyc_n, q_oe, q, e_oe, e_q);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        din = sched.exists(cyc_n) ? sched[cyc_n] : '0;
        @(negedge clk);
        #1;
        cyc_n++;
    endtask

    task automatic beat(input logic a_adv, input logic [2:0] ens, input logic we,
                        input logic [AW-1:0] a, input logic [NB-1:0] bwn, input logic [DW-1:0] d);
        adv = a_adv;
        {en_a_n, en_b, en_c_n} = ens;
        we_n = !we;
        addr = a;
        bw_n = bwn;
        sched[cyc_n + (pipe_mode ? 2 : 1)] = d;
        tick();
    endtask

    localparam logic [2:0] SEL = 3'b010;

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        beat(1'b0, SEL, 1'b1, a, '0, d);
    endtask
    task automatic rd(input logic [AW-1:0] a);
        beat(1'b0, SEL, 1'b0, a, '1, '0);
    endtask
    task automatic nop();
        beat(1'b0, 3'b101, 1'b0, '0, '1, '0);
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        pat = {a[7:0], ~a[7:0], 2'b10};
    endfunction

    task automatic run_mode(input logic pm);
        cur_req = "R1";
        rst = 1'b1; pipe_mode = pm; ilv_order = 1'b0; oe_n = 1'b0; sleep = 1'b0;
        sched.delete();
        nop(); nop(); nop();
        rst = 1'b0;
        nop();
        n_chk++;
        if (q_oe !== 1'b0 || q !== '0) begin
            n_bad++;
            $display("FAIL R1: after reset q_oe=%0b q=%h expected q_oe=0 q=0", q_oe, q);
        end
        nop();

        // R4: fill every word with late write data
        cur_req = "R4";
        for (int a = 0; a < DEPTH; a++) wr(AW'(a), pat(a));
        nop(); nop();

        // R3: isolated reads
        cur_req = "R3";
        for (int a = 3; a < 12; a += 4) begin rd(AW'(a)); nop(); nop(); end

        // R5: back-to-back random mix on a narrow window
        cur_req = "R5";
        for (int i = 0; i < 300; i++) begin
            int k = $urandom_range(0, 2);
            logic [AW-1:0] a = AW'($urandom_range(0, 5));
            if (k == 0)      rd(a);
            else if (k == 1) beat(1'b0, SEL, 1'b1, a, NB'($urandom_range(0, 3)), DW'($urandom));
            else             nop();
        end
        // R5: write then immediate reads of same word
        wr(8'd9, 18'h2AB55); rd(8'd9); wr(8'd9, 18'h01234); rd(8'd9); rd(8'd9);
        nop(); nop();

        // R6: partial byte writes
        cur_req = "R6";
        beat(1'b0, SEL, 1'b1, 8'd40, 2'b10, 18'h3FFFF);
        beat(1'b0, SEL, 1'b1, 8'd41, 2'b01, 18'h3FFFF);
        beat(1'b0, SEL, 1'b1, 8'd42, 2'b11, 18'h3FFFF);
        rd(8'd40); rd(8'd41); rd(8'd42);
        nop(); nop();

        // R2: each enable off in turn makes a deselect
        cur_req = "R2";
        beat(1'b0, 3'b110, 1'b1, 8'd20, '0, 18'h11111);
        beat(1'b0, 3'b000, 1'b1, 8'd20, '0, 18'h22222);
        beat(1'b0, 3'b011, 1'b1, 8'd20, '0, 18'h33333);
        beat(1'b0, 3'b110, 1'b0, 8'd21, '1, '0);
        rd(8'd20); nop(); nop();

        // R7: bursts, both orders, odd start
        cur_req = "R7";
        for (int o = 0; o < 2; o++) begin
            ilv_order = o[0];
            rd(8'h42);
            for (int n = 0; n < 5; n++) beat(1'b1, 3'b101, 1'b1, 8'h00, '1, '0);
            beat(1'b0, SEL, 1'b1, 8'h85, '0, 18'h0A000 + DW'(o));
            for (int n = 0; n < 3; n++) beat(1'b1, 3'b101, 1'b0, 8'h00, '0, 18'h0B000 + DW'(n * 16 + o));
            rd(8'h85);
            for (int n = 0; n < 3; n++) beat(1'b1, 3'b110, 1'b1, 8'h00, '1, '0);
            nop();
            beat(1'b1, SEL, 1'b0, 8'h10, '1, '0);
            nop(); nop();
        end

        // R8 R10: output enable cut in the middle of reads
        cur_req = "R8 R10";
        rd(8'd7); oe_n = 1'b1; rd(8'd8); rd(8'd9); oe_n = 1'b0; rd(8'd10); nop();
        oe_n = 1'b1; nop(); oe_n = 1'b0; nop(); nop();

        // R9: sleep blocks commands but keeps owed write data
        cur_req = "R9";
        wr(8'd30, 18'h15A5A);
        sleep = 1'b1;
        wr(8'd31, 18'h2F0F0);
        rd(8'd30);
        beat(1'b1, SEL, 1'b1, 8'd0, '1, '0);
        nop();
        sleep = 1'b0;
        rd(8'd30); rd(8'd31);
        rd(8'd33); sleep = 1'b1; nop(); sleep = 1'b0; nop(); nop();
    endtask

    initial begin
        rst = 1'b1; pipe_mode = 1'b1; ilv_order = 1'b0; oe_n = 1'b0; sleep = 1'b0;
        en_a_n = 1'b1; en_b = 1'b0; en_c_n = 1'b1; adv = 1'b0; we_n = 1'b1;
        bw_n = '1; addr = '0; din = '0;
        run_mode(1'b1);
        run_mode(1'b0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule